// File: doc/BRIEF.md
# Closest-Hit Minimum Search Chain

This block picks the nearest sphere hit for one ray out of a set of column results. A beat enters at the left end with a running candidate (distance, column ID, sphere constant and hit flag) plus one distance and one sphere constant for each of the C columns. The beat walks through C compare-and-select cells, one cell per clock. Each cell weighs the running candidate against its own column's distance and forwards the winner to its right-hand neighbour. The right end gives the smallest distance, the ID of the column that owns it, that column's constant, and a flag that says whether any intersection exists.

Distances are 32-bit two's-complement values. The value 0x7FFFFFFF marks "no intersection". Column values are delayed inside the block, so each cell sees the column data of the beat it is working on. Both edges use a valid/ready handshake. A beat is accepted when `in_valid` and `in_ready` are both high, and delivered when `out_valid` and `out_ready` are both high. The whole chain moves as one unit. It advances only while `pipe_en` is high and the output slot is empty or being drained. A stall freezes every stage, and empty slots inside the chain are kept rather than squeezed out.

Top module: `hit_min_chain`

## Requirements
- R1: `out_dist` is the smallest signed value among `in_dist` and all C column distances of the beat.
- R2: `out_id` is the index (0 to C-1) of the column whose distance was selected. When no column beats the incoming candidate, `out_id` equals the beat's `in_id`.
- R3: `out_const` is the constant that belongs to the selected distance: the column constant of the winning column, or `in_const` when no column wins.
- R4: On equal distances the candidate that is already running is kept, so the incoming value beats any column and a lower column index beats a higher one.
- R5: `out_hit` is 1 when `in_hit` was 1 or when the selected distance differs from 0x7FFFFFFF; otherwise it is 0.
- R6: With `pipe_en` and `out_ready` held high, a beat accepted at one clock edge appears on `out_valid` exactly C clock edges later.
- R7: While `pipe_en` is low, `in_ready` is low and no stage or output changes.
- R8: `in_ready` equals `pipe_en AND (NOT out_valid OR out_ready)`. While `out_valid` is high and `out_ready` is low, all outputs hold their values.
- R9: After reset, `out_valid`, `out_id`, `out_const` and `out_hit` are 0 and `out_dist` is 0x7FFFFFFF.
- R10: The comparison is signed, so a negative distance such as 0x80000000 beats any non-negative one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_en | input | 1 | Chain advance enable |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted this cycle |
| in_dist | input | 32 | Incoming running distance |
| in_id | input | IDW | Incoming running column ID |
| in_const | input | KW | Incoming running sphere constant |
| in_hit | input | 1 | Incoming hit flag |
| col_dist | input | C*32 | Column distances, column c at bits [c*32 +: 32] |
| col_const | input | C*KW | Column constants, column c at bits [c*KW +: KW] |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Downstream accepts result |
| out_dist | output | 32 | Nearest distance |
| out_id | output | IDW | Column ID of nearest distance |
| out_const | output | KW | Constant of nearest distance |
| out_hit | output | 1 | Intersection found |

## Verification
The bench builds the chain with C = 4 and IDW = 2, so every code in the ID space names a real column and each column can win. It uses KW = 16, which keeps the constant path narrower than the distance path so that a mix-up between the two lanes shows up. Distances are drawn from a small pool that holds duplicates, the no-hit code and the most negative value. This makes ties between the incoming candidate and a column, ties between two columns, and signed wins common, and it makes them occur while stalls and back-pressure are active.

// File: rtl/hmc_pkg.sv
package hmc_pkg;
  // Width of a distance word and the code meaning "nothing hit".
  localparam int unsigned DIST_W = 32;
  localparam logic [DIST_W-1:0] DIST_NONE = {1'b0, {(DIST_W-1){1'b1}}};
endpackage

// File: rtl/hmc_cell.sv
// Combinational compare-and-select for one column.
module hmc_cell
  import hmc_pkg::*;
#(
  parameter int unsigned IDW     = 2,
  parameter int unsigned KW      = 32,
  parameter int unsigned COL_IDX = 0
) (
  input  logic [DIST_W-1:0] run_d,
  input  logic [IDW-1:0]    run_id,
  input  logic [KW-1:0]     run_k,
  input  logic              run_hit,
  input  logic [DIST_W-1:0] col_d,
  input  logic [KW-1:0]     col_k,
  output logic [DIST_W-1:0] sel_d,
  output logic [IDW-1:0]    sel_id,
  output logic [KW-1:0]     sel_k,
  output logic              sel_hit
);
  localparam logic [IDW-1:0] OWN_ID = IDW'(COL_IDX);

  logic col_wins;

  // strict less-than: equal values keep the running candidate
  assign col_wins = $signed(col_d) < $signed(run_d);

  always_comb begin
    if (col_wins) begin
      sel_d  = col_d;
      sel_id = OWN_ID;
      sel_k  = col_k;
    end else begin
      sel_d  = run_d;
      sel_id = run_id;
      sel_k  = run_k;
    end
    sel_hit = run_hit | (sel_d != DIST_NONE);
  end
endmodule

// File: rtl/hmc_skew.sv
// Delay line that lines up one column's data with its stage.
module hmc_skew #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] taps [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
    end else if (adv) begin
      taps[0] <= d;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end

  assign q = taps[DEPTH-1];
endmodule

// File: rtl/hmc_stage.sv
// One registered stage of the chain: cell plus pipeline register.
module hmc_stage
  import hmc_pkg::*;
#(
  parameter int unsigned IDW     = 2,
  parameter int unsigned KW      = 32,
  parameter int unsigned COL_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              up_v,
  input  logic [DIST_W-1:0] up_d,
  input  logic [IDW-1:0]    up_id,
  input  logic [KW-1:0]     up_k,
  input  logic              up_hit,
  input  logic [DIST_W-1:0] col_d,
  input  logic [KW-1:0]     col_k,
  output logic              dn_v,
  output logic [DIST_W-1:0] dn_d,
  output logic [IDW-1:0]    dn_id,
  output logic [KW-1:0]     dn_k,
  output logic              dn_hit
);
  logic [DIST_W-1:0] nx_d;
  logic [IDW-1:0]    nx_id;
  logic [KW-1:0]     nx_k;
  logic              nx_hit;

  hmc_cell #(.IDW(IDW), .KW(KW), .COL_IDX(COL_IDX)) u_cell (
    .run_d  (up_d),
    .run_id (up_id),
    .run_k  (up_k),
    .run_hit(up_hit),
    .col_d  (col_d),
    .col_k  (col_k),
    .sel_d  (nx_d),
    .sel_id (nx_id),
    .sel_k  (nx_k),
    .sel_hit(nx_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_v   <= 1'b0;
      dn_d   <= DIST_NONE;
      dn_id  <= '0;
      dn_k   <= '0;
      dn_hit <= 1'b0;
    end else if (adv) begin
      dn_v   <= up_v;
      dn_d   <= nx_d;
      dn_id  <= nx_id;
      dn_k   <= nx_k;
      dn_hit <= nx_hit;
    end
  end
endmodule

// File: rtl/hit_min_chain.sv
// Pipelined left-to-right nearest-hit search over C columns.
module hit_min_chain
  import hmc_pkg::*;
#(
  parameter int unsigned C   = 4,
  parameter int unsigned IDW = 2,
  parameter int unsigned KW  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pipe_en,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DIST_W-1:0]   in_dist,
  input  logic [IDW-1:0]      in_id,
  input  logic [KW-1:0]       in_const,
  input  logic                in_hit,
  input  logic [C*DIST_W-1:0] col_dist,
  input  logic [C*KW-1:0]     col_const,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DIST_W-1:0]   out_dist,
  output logic [IDW-1:0]      out_id,
  output logic [KW-1:0]       out_const,
  output logic                out_hit
);
  localparam int unsigned LAST = C;

  logic                v   [C+1];
  logic [DIST_W-1:0]   d   [C+1];
  logic [IDW-1:0]      id  [C+1];
  logic [KW-1:0]       k   [C+1];
  logic                hit [C+1];
  logic [DIST_W-1:0]   cd  [C];
  logic [KW-1:0]       ck  [C];
  logic                adv;

  // the whole chain shifts together; the last slot gates it
  assign adv      = pipe_en & (~v[LAST] | out_ready);
  assign in_ready = adv;

  assign v[0]   = in_valid;
  assign d[0]   = in_dist;
  assign id[0]  = in_id;
  assign k[0]   = in_const;
  assign hit[0] = in_hit;

  for (genvar c = 0; c < C; c++) begin : g_col
    if (c == 0) begin : g_direct
      assign cd[c] = col_dist[c*DIST_W +: DIST_W];
      assign ck[c] = col_const[c*KW +: KW];
    end else begin : g_delay
      hmc_skew #(.W(DIST_W), .DEPTH(c)) u_skew_d (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (adv),
        .d    (col_dist[c*DIST_W +: DIST_W]),
        .q    (cd[c])
      );
      hmc_skew #(.W(KW), .DEPTH(c)) u_skew_k (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (adv),
        .d    (col_const[c*KW +: KW]),
        .q    (ck[c])
      );
    end

    hmc_stage #(.IDW(IDW), .KW(KW), .COL_IDX(c)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .up_v  (v[c]),
      .up_d  (d[c]),
      .up_id (id[c]),
      .up_k  (k[c]),
      .up_hit(hit[c]),
      .col_d (cd[c]),
      .col_k (ck[c]),
      .dn_v  (v[c+1]),
      .dn_d  (d[c+1]),
      .dn_id (id[c+1]),
      .dn_k  (k[c+1]),
      .dn_hit(hit[c+1])
    );
  end

  assign out_valid = v[LAST];
  assign out_dist  = d[LAST];
  assign out_id    = id[LAST];
  assign out_const = k[LAST];
  assign out_hit   = hit[LAST];
endmodule

// File: rtl/hit_min_chain_chk.sv
module hit_min_chain_chk
  import hmc_pkg::*;
#(
  parameter int unsigned IDW = 2,
  parameter int unsigned KW  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_en,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DIST_W-1:0] out_dist,
  input logic [IDW-1:0]    out_id,
  input logic [KW-1:0]     out_const,
  input logic              out_hit
);
  // R7
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_en |-> !in_ready);

  // R7
  stall_freezes_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_en |=> $stable(out_valid) && $stable(out_dist) && $stable(out_id)
                 && $stable(out_const) && $stable(out_hit));

  // R8
  backpressure_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dist) && $stable(out_id)
                                && $stable(out_const) && $stable(out_hit));

  // R5
  hit_on_real_distance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_dist != DIST_NONE) |-> out_hit);

  // R8
  drain_opens_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_en && out_ready |-> in_ready);
endmodule

bind hit_min_chain hit_min_chain_chk #(.IDW(IDW), .KW(KW)) u_hmc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pipe_en  (pipe_en),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_dist (out_dist),
  .out_id   (out_id),
  .out_const(out_const),
  .out_hit  (out_hit)
);

// File: tb/test_hit_min_chain.sv
`timescale 1ns/1ps
module test_hit_min_chain;
  localparam int C   = 4;
  localparam int IDW = 2;
  localparam int KW  = 16;
  localparam int DW  = 32;
  localparam logic [DW-1:0] NONE = 32'h7FFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pipe_en = 1'b0, in_valid = 1'b0, out_ready = 1'b0, in_hit = 1'b0;
  logic [DW-1:0] in_dist = '0;
  logic [IDW-1:0] in_id = '0;
  logic [KW-1:0] in_const = '0;
  logic [C*DW-1:0] col_dist = '0;
  logic [C*KW-1:0] col_const = '0;
  logic in_ready, out_valid, out_hit;
  logic [DW-1:0] out_dist;
  logic [IDW-1:0] out_id;
  logic [KW-1:0] out_const;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hit_min_chain #(.C(C), .IDW(IDW), .KW(KW)) i_hit_min_chain (
    .clk(clk), .rst_n(rst_n), .pipe_en(pipe_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_dist(in_dist), .in_id(in_id), .in_const(in_const),
    .in_hit(in_hit), .col_dist(col_dist), .col_const(col_const),
    .out_valid(out_valid), .out_ready(out_ready), .out_dist(out_dist),
    .out_id(out_id), .out_const(out_const), .out_hit(out_hit)
  );

  // reference slots: index C-1 is what the output should show
  logic          mv [C];
  logic [DW-1:0] md [C];
  logic [IDW-1:0] mi [C];
  logic [KW-1:0] mk [C];
  logic          mh [C];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic ordy, input logic iv,
                      input logic [DW-1:0] idist, input logic [IDW-1:0] iid,
                      input logic [KW-1:0] ik, input logic ih,
                      input logic [C*DW-1:0] cdist, input logic [C*KW-1:0] ck);
    logic adv;
    logic [DW-1:0] bd;
    logic [IDW-1:0] bi;
    logic [KW-1:0] bk;
    @(negedge clk);
    chk(out_valid === mv[C-1], "R8", "out_valid", 64'(out_valid), 64'(mv[C-1]));
    if (mv[C-1]) begin
      chk(out_dist === md[C-1], "R1", "out_dist", 64'(out_dist), 64'(md[C-1]));
      chk(out_id === mi[C-1], "R2", "out_id", 64'(out_id), 64'(mi[C-1]));
      chk(out_const === mk[C-1], "R3", "out_const", 64'(out_const), 64'(mk[C-1]));
      chk(out_hit === mh[C-1], "R5", "out_hit", 64'(out_hit), 64'(mh[C-1]));
    end
    pipe_en = en; out_ready = ordy; in_valid = iv; in_dist = idist; in_id = iid;
    in_const = ik; in_hit = ih; col_dist = cdist; col_const = ck;
    adv = en && (!mv[C-1] || ordy);
    #1;
    chk(in_ready === adv, "R7", "in_ready", 64'(in_ready), 64'(adv));
    if (adv) begin
      bd = idist; bi = iid; bk = ik;
      for (int c = 0; c < C; c++) begin
        if ($signed(cdist[c*DW +: DW]) < $signed(bd)) begin
          bd = cdist[c*DW +: DW]; bi = IDW'(c); bk = ck[c*KW +: KW];
        end
      end
      for (int s = C-1; s > 0; s--) begin
        mv[s] = mv[s-1]; md[s] = md[s-1]; mi[s] = mi[s-1]; mk[s] = mk[s-1]; mh[s] = mh[s-1];
      end
      mv[0] = iv; md[0] = bd; mi[0] = bi; mk[0] = bk; mh[0] = ih || (bd != NONE);
    end
  endtask

  function automatic logic [DW-1:0] pick_dist();
    case ($urandom % 8)
      0: return NONE;
      1: return 32'hFFFF_FFFB;
      2: return 32'd0;
      3, 4: return 32'd3;
      5: return 32'd100;
      6: return 32'h8000_0000;
      default: return 32'(($urandom % 50));
    endcase
  endfunction

  function automatic logic [C*DW-1:0] pack_d(input logic [DW-1:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  localparam logic [C*KW-1:0] KSET = {16'hD003, 16'hC002, 16'hB001, 16'hA000};

  // one beat into an idle chain, returns edges until out_valid
  task automatic send_one(input logic [DW-1:0] idist, input logic [IDW-1:0] iid,
                          input logic [KW-1:0] ik, input logic ih,
                          input logic [C*DW-1:0] cdist, output int lat);
    step(1, 1, 1, idist, iid, ik, ih, cdist, KSET);
    lat = 0;
    for (int n = 0; n < 20; n++) begin
      step(1, 1, 0, '0, '0, '0, 0, '0, '0);
      lat++;
      if (out_valid) break;
    end
  endtask

  initial begin
    int lat;
    for (int s = 0; s < C; s++) begin
      mv[s] = 0; md[s] = NONE; mi[s] = '0; mk[s] = '0; mh[s] = 0;
    end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(out_valid === 1'b0, "R9", "out_valid", 64'(out_valid), 0);
    chk(out_dist === NONE, "R9", "out_dist", 64'(out_dist), 64'(NONE));
    chk(out_id === '0 && out_hit === 1'b0 && out_const === '0, "R9", "id/hit/const",
        64'({out_id, out_hit, out_const}), 0);
    rst_n = 1'b1;

    // R6 latency and R4 tie with incoming candidate
    send_one(32'd10, 2'd3, 16'h5555, 0, pack_d(32'd10, 32'd10, 32'd10, 32'd10), lat);
    chk(lat == C, "R6", "latency", 64'(lat), 64'(C));
    chk(out_id === 2'd3 && out_const === 16'h5555, "R4", "tie keeps incoming",
        64'({out_id, out_const}), 64'({2'd3, 16'h5555}));
    // R4 tie between columns 1 and 3
    send_one(32'd50, 2'd0, 16'h1111, 0, pack_d(32'd9, 32'd5, 32'd7, 32'd5), lat);
    chk(out_id === 2'd1 && out_const === 16'hB001, "R4", "lower column wins tie",
        64'({out_id, out_const}), 64'({2'd1, 16'hB001}));
    // R10 signed comparison
    send_one(32'd1, 2'd0, 16'h2222, 0, pack_d(32'd0, 32'd2, 32'h8000_0000, 32'd4), lat);
    chk(out_id === 2'd2 && out_dist === 32'h8000_0000, "R10", "negative wins",
        64'({out_id, out_dist}), 64'({2'd2, 32'h8000_0000}));
    // R5 nothing hit
    send_one(NONE, 2'd0, 16'h0, 0, pack_d(NONE, NONE, NONE, NONE), lat);
    chk(out_hit === 1'b0 && out_dist === NONE, "R5", "no hit", 64'(out_hit), 0);
    send_one(NONE, 2'd0, 16'h0, 1, pack_d(NONE, NONE, NONE, NONE), lat);
    chk(out_hit === 1'b1, "R5", "incoming hit kept", 64'(out_hit), 1);
    // R3 last column wins
    send_one(32'd90, 2'd0, 16'h3333, 0, pack_d(32'd80, 32'd70, 32'd60, 32'd1), lat);
    chk(out_const === 16'hD003 && out_id === 2'd3, "R3", "constant follows",
        64'({out_id, out_const}), 64'({2'd3, 16'hD003}));

    // R7 stall: fill, then hold pipe_en low and watch outputs
    for (int n = 0; n < C; n++)
      step(1, 0, 1, 32'(n + 20), 2'd0, 16'(n), 0, pack_d(NONE, 32'(n), NONE, NONE), KSET);
    for (int n = 0; n < 5; n++)
      step(0, 1, 1, 32'd0, 2'd0, 16'h0, 0, '0, '0);
    chk(out_valid === 1'b1 && out_dist === 32'd0, "R7", "frozen while disabled",
        64'(out_dist), 0);

    // mixed random traffic with stalls and back-pressure
    for (int n = 0; n < 4000; n++) begin
      logic [C*DW-1:0] cdv;
      logic [C*KW-1:0] ckv;
      for (int c = 0; c < C; c++) begin
        cdv[c*DW +: DW] = pick_dist();
        ckv[c*KW +: KW] = 16'($urandom);
      end
      step(($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 10) < 7,
           pick_dist(), IDW'($urandom), 16'($urandom), ($urandom % 6) == 0, cdv, ckv);
    end
    for (int n = 0; n < C + 2; n++) step(1, 1, 0, '0, '0, '0, 0, '0, '0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule